// File: doc/BRIEF.md
# Branch Sequencer

This block resolves a single control-transfer operation for a small 8-bit processor core. A one-cycle `start` pulse hands it the decoded operation kind, a condition selector, the zero and carry flags, the address of the following instruction, and the operands: a signed displacement, a 16-bit target (an immediate address or the HL register value), and a restart vector index. The block works out whether the transfer is taken and which address comes next. It then holds `busy` for the fixed number of clock cycles that the operation costs.

Stack traffic happens in the first busy cycle. A call or restart issues one push beat that carries the full return address. A return issues one pop request and loads the popped word as the next address. Every stack beat comes with a stack-pointer adjustment code on its own output. A one-cycle `done` pulse marks the last cycle of the cost. Return-from-interrupt also raises an interrupt-enable strobe in that same cycle.

Top module: `brseq_top`

## Requirements
- R1: Condition selector codes are 0 = zero flag clear, 1 = zero flag set, 2 = carry flag clear, 3 = carry flag set. Codes 4 to 7 always pass.
- R2: Kind 0 is the relative jump. When taken, `next_pc` = `pc` + sign-extended `offset`, wrapping modulo 2^16, with a cost of 12 cycles. When not taken, `next_pc` = `pc` with a cost of 8 cycles.
- R3: Kind 1 is the absolute jump: `target` when taken (16 cycles), `pc` when not (12 cycles). Kind 2 is the jump to HL: it ignores the condition, always goes to `target`, and costs 4 cycles. Kind 7 is a no-op: not taken, `next_pc` = `pc`, 4 cycles, no stack activity.
- R4: Kind 3 is the call. When taken, it raises `push_req` for exactly one beat in the first busy cycle, with `push_data` = `pc` and `sp_op` = 2'b01 (stack pointer minus 2), and goes to `target` (24 cycles). When not taken, it makes no push and costs 12 cycles.
- R5: Kind 4 is the return. When taken, it raises `pop_req` for one beat in the first busy cycle, with `sp_op` = 2'b10 (stack pointer plus 2), and `next_pc` becomes the `pop_data` present in that cycle. A conditional return costs 20 cycles taken and 8 not taken. With an always-pass selector it costs 16 cycles. `sp_op` is 2'b00 in every cycle without a stack beat.
- R6: Kind 6 is the restart. It ignores the condition, pushes `pc` as in R4, goes to `rst_vec` × 8, and costs 16 cycles.
- R7: Kind 5 is return-from-interrupt. It ignores the condition, pops as in R5, costs 16 cycles, and pulses `ime_set` in the `done` cycle. No other kind ever raises `ime_set`.
- R8: `done` is high for exactly one cycle, the Nth cycle after the accepting edge, where N is the cost. `next_pc` and `taken` are valid in that cycle. `busy` is high from cycle 1 to cycle N and low afterwards.
- R9: `start` is accepted only while `busy` is low. A `start` pulse during an operation changes neither its cost nor its results.
- R10: After reset, `busy`, `done`, `push_req`, `pop_req` and `ime_set` are low and `sp_op` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (ignored while busy) |
| kind | input | 3 | Operation kind code |
| cond | input | 3 | Condition selector |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| pc | input | 16 | Address of the following instruction |
| offset | input | 8 | Signed relative displacement |
| target | input | 16 | Immediate address or HL value |
| rst_vec | input | 3 | Restart vector index |
| pop_data | input | 16 | Word returned by the stack for a pop |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of the operation |
| taken | output | 1 | Transfer taken, valid with done |
| next_pc | output | 16 | Resulting program counter, valid with done |
| push_req | output | 1 | Push one word |
| push_data | output | 16 | Word to push |
| pop_req | output | 1 | Pop one word |
| sp_op | output | 2 | Stack pointer adjustment: 00 none, 01 minus 2, 10 plus 2 |
| ime_set | output | 1 | Set interrupt master enable |

## Verification
On every cycle the assertions check several rules that hold for any stream of operations. `done` is a single-cycle pulse and only occurs while busy. The elapsed count at `done` is a legal cost. Stack beats occur only in the first busy cycle, never both at once, and always with the matching `sp_op`. A popped word reaches `next_pc`. `ime_set` appears only with `done`. The bench scenarios are needed to show what depends on the operation kind: the taken decision for each flag and selector combination, the exact cost on each path, wrapped relative addresses, restart vectors, the pushed return address, and that a `start` during an operation leaves it undisturbed.

// File: rtl/brseq_pkg.sv
package brseq_pkg;
  localparam int COST_W = 5;

  typedef enum logic [2:0] {
    K_REL  = 3'd0,
    K_ABS  = 3'd1,
    K_HL   = 3'd2,
    K_CALL = 3'd3,
    K_RET  = 3'd4,
    K_RETI = 3'd5,
    K_RST  = 3'd6,
    K_NONE = 3'd7
  } br_kind_e;

  typedef enum logic [1:0] {
    SP_NONE = 2'b00,
    SP_DEC  = 2'b01,
    SP_INC  = 2'b10
  } sp_op_e;

  // Fixed cycle cost for each kind and path
  function automatic logic [COST_W-1:0] br_cost(br_kind_e k, logic tk, logic always_c);
    logic [COST_W-1:0] c;
    case (k)
      K_REL:   c = tk ? 5'd12 : 5'd8;
      K_ABS:   c = tk ? 5'd16 : 5'd12;
      K_HL:    c = 5'd4;
      K_CALL:  c = tk ? 5'd24 : 5'd12;
      K_RET:   c = always_c ? 5'd16 : (tk ? 5'd20 : 5'd8);
      K_RETI:  c = 5'd16;
      K_RST:   c = 5'd16;
      default: c = 5'd4;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/brseq_cond.sv
module brseq_cond (
  input  logic [2:0] cond,
  input  logic       flag_z,
  input  logic       flag_c,
  output logic       pass,
  output logic       is_always
);
  always_comb begin
    is_always = cond[2];
    case (cond[1:0])
      2'd0:    pass = ~flag_z;
      2'd1:    pass = flag_z;
      2'd2:    pass = ~flag_c;
      default: pass = flag_c;
    endcase
    if (cond[2]) pass = 1'b1;
  end
endmodule

// File: rtl/brseq_target.sv
module brseq_target
  import brseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 8,
  parameter int VEC_W      = 3,
  parameter int VEC_STRIDE = 8
) (
  input  br_kind_e          kind,
  input  logic              pass,
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  offset,
  input  logic [ADDR_W-1:0] target,
  input  logic [VEC_W-1:0]  rst_vec,
  output logic              taken,
  output logic [ADDR_W-1:0] jump_pc,
  output logic              needs_push,
  output logic              needs_pop
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] rel_pc;
  logic [ADDR_W-1:0] vec_pc;

  assign rel_pc = pc + {{EXT_W{offset[OFF_W-1]}}, offset};
  assign vec_pc = ADDR_W'(int'(rst_vec) * VEC_STRIDE);

  always_comb begin
    case (kind)
      K_REL, K_ABS, K_CALL, K_RET: taken = pass;
      K_HL, K_RETI, K_RST:         taken = 1'b1;
      default:                     taken = 1'b0;
    endcase

    jump_pc = pc;
    if (taken) begin
      case (kind)
        K_REL:                jump_pc = rel_pc;
        K_ABS, K_CALL, K_HL:  jump_pc = target;
        K_RST:                jump_pc = vec_pc;
        default:              jump_pc = pc;
      endcase
    end

    needs_push = taken && (kind == K_CALL || kind == K_RST);
    needs_pop  = taken && (kind == K_RET  || kind == K_RETI);
  end
endmodule

// File: rtl/brseq_timer.sv
module brseq_timer #(
  parameter int COST_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [COST_W-1:0] cost,
  output logic              busy,
  output logic              done
);
  logic [COST_W-1:0] cnt;
  logic [COST_W-1:0] cost_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      cost_q <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      cnt    <= COST_W'(1);
      cost_q <= cost;
      done   <= (cost == COST_W'(1));
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
        done <= 1'b0;
      end else begin
        cnt  <= cnt + COST_W'(1);
        done <= ((cnt + COST_W'(1)) == cost_q);
      end
    end
  end
endmodule

// File: rtl/brseq_top.sv
module brseq_top
  import brseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 8,
  parameter int VEC_W      = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        kind,
  input  logic [2:0]        cond,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  offset,
  input  logic [ADDR_W-1:0] target,
  input  logic [VEC_W-1:0]  rst_vec,
  input  logic [ADDR_W-1:0] pop_data,
  output logic              busy,
  output logic              done,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc,
  output logic              push_req,
  output logic [ADDR_W-1:0] push_data,
  output logic              pop_req,
  output logic [1:0]        sp_op,
  output logic              ime_set
);
  br_kind_e          kind_e;
  logic              pass, is_always, tk_c, push_c, pop_c, accept;
  logic [ADDR_W-1:0] jump_c;
  logic [COST_W-1:0] cost_c;
  logic              reti_q;

  assign kind_e = br_kind_e'(kind);
  assign accept = start && !busy;
  assign cost_c = br_cost(kind_e, tk_c, is_always);

  brseq_cond u_cond (
    .cond(cond), .flag_z(flag_z), .flag_c(flag_c),
    .pass(pass), .is_always(is_always)
  );

  brseq_target #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .VEC_W(VEC_W), .VEC_STRIDE(VEC_STRIDE)
  ) u_target (
    .kind(kind_e), .pass(pass), .pc(pc), .offset(offset), .target(target),
    .rst_vec(rst_vec), .taken(tk_c), .jump_pc(jump_c),
    .needs_push(push_c), .needs_pop(pop_c)
  );

  brseq_timer #(.COST_W(COST_W)) u_timer (
    .clk(clk), .rst(rst), .load(accept), .cost(cost_c),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken     <= 1'b0;
      next_pc   <= '0;
      push_req  <= 1'b0;
      push_data <= '0;
      pop_req   <= 1'b0;
      sp_op     <= SP_NONE;
      reti_q    <= 1'b0;
    end else if (accept) begin
      taken     <= tk_c;
      next_pc   <= jump_c;
      push_req  <= push_c;
      push_data <= pc;
      pop_req   <= pop_c;
      sp_op     <= push_c ? SP_DEC : (pop_c ? SP_INC : SP_NONE);
      reti_q    <= (kind_e == K_RETI);
    end else begin
      if (pop_req) next_pc <= pop_data;
      push_req <= 1'b0;
      pop_req  <= 1'b0;
      sp_op    <= SP_NONE;
    end
  end

  assign ime_set = done && reti_q;
endmodule

// File: rtl/brseq_checker.sv
module brseq_checker (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        push_req,
  input logic        pop_req,
  input logic [1:0]  sp_op,
  input logic        ime_set,
  input logic [15:0] pop_data,
  input logic [15:0] next_pc
);
  logic [5:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst) elapsed <= '0;
    else if (start && !busy) elapsed <= 6'd1;
    else if (busy) elapsed <= elapsed + 6'd1;
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  assert_done_cost_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (elapsed[1:0] == 2'b00 && elapsed >= 6'd4 && elapsed <= 6'd24));
  assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_push_first_R4: assert property (@(posedge clk) disable iff (rst)
    push_req |-> $past(start && !busy));
  assert_push_sp_R4: assert property (@(posedge clk) disable iff (rst)
    push_req |-> sp_op == 2'b01);
  assert_pop_first_R5: assert property (@(posedge clk) disable iff (rst)
    pop_req |-> $past(start && !busy));
  assert_pop_sp_R5: assert property (@(posedge clk) disable iff (rst)
    pop_req |-> sp_op == 2'b10);
  assert_no_both_R5: assert property (@(posedge clk) disable iff (rst)
    !(push_req && pop_req));
  assert_sp_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!push_req && !pop_req) |-> sp_op == 2'b00);
  assert_pop_load_R5: assert property (@(posedge clk) disable iff (rst)
    pop_req |=> next_pc == $past(pop_data));
  assert_ime_done_R7: assert property (@(posedge clk) disable iff (rst)
    ime_set |-> done);
endmodule

bind brseq_top brseq_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .push_req(push_req), .pop_req(pop_req), .sp_op(sp_op), .ime_set(ime_set),
  .pop_data(pop_data), .next_pc(next_pc)
);

// File: tb/tb_brseq_top.sv
module tb_brseq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  kind = '0, cond = '0, rst_vec = '0;
  logic        flag_z = 1'b0, flag_c = 1'b0;
  logic [15:0] pc = '0, target = '0, pop_data = '0;
  logic [7:0]  offset = '0;
  logic        busy, done, taken, push_req, pop_req, ime_set;
  logic [15:0] next_pc, push_data;
  logic [1:0]  sp_op;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brseq_top dut (
    .clk(clk), .rst(rst), .start(start), .kind(kind), .cond(cond),
    .flag_z(flag_z), .flag_c(flag_c), .pc(pc), .offset(offset),
    .target(target), .rst_vec(rst_vec), .pop_data(pop_data),
    .busy(busy), .done(done), .taken(taken), .next_pc(next_pc),
    .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
    .sp_op(sp_op), .ime_set(ime_set)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Launch one operation and check every observable result
  task automatic run_op(input logic [2:0] k, input logic [2:0] cd, input logic z, input logic c,
                        input logic [15:0] p, input logic [7:0] off, input logic [15:0] tgt,
                        input logic [2:0] vec, input logic [15:0] popw,
                        input int exp_cost, input logic [15:0] exp_pc, input logic exp_tk,
                        input logic exp_push, input logic exp_pop, input logic exp_ime,
                        input bit poke, input string tag);
    int npush = 0, npop = 0, nime = 0, got = 0;
    logic [15:0] pword = '0;
    bit sp_bad = 0;
    @(negedge clk);
    kind = k; cond = cd; flag_z = z; flag_c = c; pc = p; offset = off;
    target = tgt; rst_vec = vec; pop_data = popw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= 40; i++) begin
      if (poke && i == 3) begin start = 1'b1; kind = 3'd2; target = 16'hDEAD; end
      if (poke && i == 4) start = 1'b0;
      if (push_req) begin npush++; pword = push_data; if (sp_op != 2'b01) sp_bad = 1; end
      if (pop_req)  begin npop++;  if (sp_op != 2'b10) sp_bad = 1; end
      if (!push_req && !pop_req && sp_op != 2'b00) sp_bad = 1;
      if (ime_set) nime++;
      if (done) begin
        got = i;
        chk(next_pc == exp_pc, {tag, " next_pc R8"}, next_pc, exp_pc);
        chk(taken == exp_tk, {tag, " taken R8"}, taken, exp_tk);
        break;
      end
      @(negedge clk);
    end
    chk(got == exp_cost, {tag, " cost R8"}, got, exp_cost);
    chk(npush == int'(exp_push), {tag, " push count R4"}, npush, exp_push);
    if (exp_push) chk(pword == p, {tag, " push word R4"}, pword, p);
    chk(npop == int'(exp_pop), {tag, " pop count R5"}, npop, exp_pop);
    chk(!sp_bad, {tag, " sp_op R5"}, sp_bad, 0);
    chk(nime == int'(exp_ime), {tag, " ime R7"}, nime, exp_ime);
    @(negedge clk);
    chk(!done && !busy, {tag, " idle after done R8 R9"}, {done, busy}, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !push_req && !pop_req && !ime_set && sp_op == 2'b00,
        "R10 reset state", {busy, done, push_req, pop_req, ime_set, sp_op}, 0);
  endtask

  task automatic t_rel;
    run_op(3'd0, 3'd0, 0, 0, 16'h1000, 8'h10, 16'h0, 3'd0, 16'h0, 12, 16'h1010, 1, 0, 0, 0, 0, "R2 fwd");
    run_op(3'd0, 3'd4, 0, 0, 16'hFFFE, 8'h05, 16'h0, 3'd0, 16'h0, 12, 16'h0003, 1, 0, 0, 0, 0, "R2 wrap up");
    run_op(3'd0, 3'd7, 0, 0, 16'h0002, 8'h80, 16'h0, 3'd0, 16'h0, 12, 16'hFF82, 1, 0, 0, 0, 0, "R2 wrap down");
    run_op(3'd0, 3'd1, 0, 0, 16'h1234, 8'h10, 16'h0, 3'd0, 16'h0, 8, 16'h1234, 0, 0, 0, 0, 0, "R2 not taken");
  endtask

  // R1 matrix over flags using the absolute jump
  task automatic t_cond;
    for (int cd = 0; cd < 8; cd++) begin
      for (int f = 0; f < 4; f++) begin
        logic z = f[0], c = f[1], ok;
        case (cd)
          0: ok = !z;
          1: ok = z;
          2: ok = !c;
          3: ok = c;
          default: ok = 1'b1;
        endcase
        run_op(3'd1, 3'(cd), z, c, 16'h4000, 8'h0, 16'h8123, 3'd0, 16'h0,
               ok ? 16 : 12, ok ? 16'h8123 : 16'h4000, ok, 0, 0, 0, 0, "R1 R3 abs");
      end
    end
  endtask

  task automatic t_misc;
    run_op(3'd2, 3'd0, 1, 0, 16'h0100, 8'h0, 16'hC0DE, 3'd0, 16'h0, 4, 16'hC0DE, 1, 0, 0, 0, 0, "R3 hl");
    run_op(3'd7, 3'd4, 0, 0, 16'h0200, 8'h7F, 16'hAAAA, 3'd3, 16'h0, 4, 16'h0200, 0, 0, 0, 0, 0, "R3 none");
  endtask

  task automatic t_call;
    run_op(3'd3, 3'd3, 0, 1, 16'h2345, 8'h0, 16'h6000, 3'd0, 16'h0, 24, 16'h6000, 1, 1, 0, 0, 0, "R4 call taken");
    run_op(3'd3, 3'd2, 0, 1, 16'h2345, 8'h0, 16'h6000, 3'd0, 16'h0, 12, 16'h2345, 0, 0, 0, 0, 0, "R4 call skip");
  endtask

  task automatic t_ret;
    run_op(3'd4, 3'd1, 1, 0, 16'h3000, 8'h0, 16'h0, 3'd0, 16'hBEEF, 20, 16'hBEEF, 1, 0, 1, 0, 0, "R5 ret taken");
    run_op(3'd4, 3'd0, 1, 0, 16'h3000, 8'h0, 16'h0, 3'd0, 16'hBEEF, 8, 16'h3000, 0, 0, 0, 0, 0, "R5 ret skip");
    run_op(3'd4, 3'd4, 1, 1, 16'h3000, 8'h0, 16'h0, 3'd0, 16'h1357, 16, 16'h1357, 1, 0, 1, 0, 0, "R5 ret always");
  endtask

  task automatic t_reti;
    run_op(3'd5, 3'd0, 1, 1, 16'h3100, 8'h0, 16'h0, 3'd0, 16'h0A0B, 16, 16'h0A0B, 1, 0, 1, 1, 0, "R7 reti");
  endtask

  task automatic t_rst;
    run_op(3'd6, 3'd1, 0, 0, 16'h5555, 8'h0, 16'h0, 3'd7, 16'h0, 16, 16'h0038, 1, 1, 0, 0, 0, "R6 rst 7");
    run_op(3'd6, 3'd3, 0, 0, 16'h0777, 8'h0, 16'h0, 3'd2, 16'h0, 16, 16'h0010, 1, 1, 0, 0, 0, "R6 rst 2");
  endtask

  task automatic t_busy;
    run_op(3'd3, 3'd4, 0, 0, 16'h1111, 8'h0, 16'h7777, 3'd0, 16'h0, 24, 16'h7777, 1, 1, 0, 0, 1, "R9 start while busy");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_rel;
    t_cond;
    t_misc;
    t_call;
    t_ret;
    t_reti;
    t_rst;
    t_busy;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule